// File: doc/BRIEF.md
# Optical Transmit Pin Modulator

This block drives the optical transmit pin of a metering chip. A two-bit source
select picks what goes out on the pin: the serial transmit line of the UART, a
general-purpose output bit, the real-energy pulse or the reactive-energy pulse.
The chosen bit may be inverted. It may then be gated by an infrared carrier
whose frequency is derived from the system clock. The carrier's high time is
set by a two-bit duty field.

The block also routes the optical receive pin. Normally the pin feeds the UART
receiver. When the receive-disable control is set, the pin is released to serve
as general-purpose input bit 1, and the UART receiver sees an idle (high) line.
Software writes the control fields, and the block registers them internally.

Top module: `opt_tx_modulator`

## Requirements
- R1: Source select encoding: 0 selects `uart_txd`, 1 selects `gpio_out2`, 2 selects `wpulse`, 3 selects `vpulse`.
- R2: When `tx_inv` is 1, the selected bit is inverted before it reaches the pin or the carrier gate.
- R3: With `mod_en` at 0, `tx_pin` equals the selected, possibly inverted, bit. A change on a source appears one clock later. A change on a control field appears two clocks later.
- R4: With `mod_en` at 1 and the bit at 1, the pin carries a square carrier whose period is PERIOD = CLK_HZ / CARRIER_HZ clock cycles. Each period starts with its high phase.
- R5: The high time per period is PERIOD*(4-d)/8 cycles for duty field d: 0 gives 50%, 1 gives 37.5%, 2 gives 25% and 3 gives 12.5%.
- R6: With `mod_en` at 1 and the bit at 0, the pin stays low.
- R7: A change of `duty_sel` takes effect only at the next carrier period boundary. The period in progress keeps its high time.
- R8: With `rx_dis` at 0, `uart_rxd` follows `rx_pin` and `gpio_in1` is 0. With `rx_dis` at 1, `gpio_in1` follows `rx_pin` and `uart_rxd` is held at 1.
- R9: During reset, `tx_pin` is 0 and the carrier counter is cleared. Select, inversion and modulation return to 0, and the duty field returns to 50%.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_sel | input | 2 | Pin source select |
| tx_inv | input | 1 | Invert the selected bit |
| mod_en | input | 1 | Gate the bit with the carrier |
| duty_sel | input | 2 | Carrier duty field |
| rx_dis | input | 1 | Release the receive pin to general-purpose input |
| uart_txd | input | 1 | UART serial transmit bit |
| gpio_out2 | input | 1 | General-purpose output bit 2 |
| wpulse | input | 1 | Real-energy pulse |
| vpulse | input | 1 | Reactive-energy pulse |
| rx_pin | input | 1 | Optical receive pin level |
| tx_pin | output | 1 | Optical transmit pin level |
| uart_rxd | output | 1 | Receive line to the UART |
| gpio_in1 | output | 1 | General-purpose input bit 1 |

## Verification
The bench builds the block with CLK_HZ = 1600 and CARRIER_HZ = 100, which gives a 16-cycle carrier. With that setting every duty code yields a distinct whole number of high cycles (8, 6, 4 and 2). Many period boundaries also fall within a short run. This makes it practical to measure run lengths and rising-edge spacing at the pin. It also lets the bench change the duty field in the middle of a high phase and watch the old and the new high times on consecutive periods.

// File: rtl/opt_tx_pkg.sv
package opt_tx_pkg;

  typedef enum logic [1:0] {
    SRC_UART  = 2'd0,
    SRC_GPIO  = 2'd1,
    SRC_WPULS = 2'd2,
    SRC_VPULS = 2'd3
  } tx_src_e;

  typedef struct packed {
    tx_src_e sel;
    logic    inv;
    logic    mod;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = '{sel: SRC_UART, inv: 1'b0, mod: 1'b0};

  // High cycles of one carrier period for a duty code: eighths of the period.
  function automatic int unsigned carrier_high(input int unsigned period,
                                               input logic [1:0] duty);
    int unsigned eighths;
    eighths = 4 - int'(duty);
    return (period * eighths) / 8;
  endfunction

endpackage

// File: rtl/opt_src_mux.sv
module opt_src_mux
  import opt_tx_pkg::*;
(
  input  tx_cfg_t cfg,
  input  logic    uart_txd,
  input  logic    gpio_out2,
  input  logic    wpulse,
  input  logic    vpulse,
  output logic    sel_bit
);
  logic raw;

  always_comb begin
    unique case (cfg.sel)
      SRC_UART:  raw = uart_txd;
      SRC_GPIO:  raw = gpio_out2;
      SRC_WPULS: raw = wpulse;
      default:   raw = vpulse;
    endcase
  end

  assign sel_bit = raw ^ cfg.inv;
endmodule

// File: rtl/opt_carrier_gen.sv
module opt_carrier_gen
  import opt_tx_pkg::*;
#(
  parameter int unsigned PERIOD = 128,
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       duty_sel,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] hi_q,
  output logic             boundary,
  output logic             carrier
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] HI_RST = CNT_W'(carrier_high(PERIOD, 2'd0));

  logic [CNT_W-1:0] hi_next;

  assign boundary = (cnt_q == LAST);
  assign hi_next  = CNT_W'(carrier_high(PERIOD, duty_sel));
  assign carrier  = (cnt_q < hi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= HI_RST;
    end else if (boundary) begin
      cnt_q <= '0;
      hi_q  <= hi_next;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/opt_rx_route.sv
module opt_rx_route (
  input  logic rx_pin,
  input  logic rx_dis,
  output logic uart_rxd,
  output logic gpio_in1
);
  assign uart_rxd = rx_dis ? 1'b1 : rx_pin;
  assign gpio_in1 = rx_dis ? rx_pin : 1'b0;
endmodule

// File: rtl/opt_tx_modulator.sv
module opt_tx_modulator
  import opt_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 4915200,
  parameter int unsigned CARRIER_HZ = 38400,
  localparam int unsigned PERIOD = CLK_HZ / CARRIER_HZ,
  localparam int unsigned CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tx_sel,
  input  logic       tx_inv,
  input  logic       mod_en,
  input  logic [1:0] duty_sel,
  input  logic       rx_dis,
  input  logic       uart_txd,
  input  logic       gpio_out2,
  input  logic       wpulse,
  input  logic       vpulse,
  input  logic       rx_pin,
  output logic       tx_pin,
  output logic       uart_rxd,
  output logic       gpio_in1
);
  tx_cfg_t          cfg_q;
  logic             sel_bit;
  logic             carrier;
  logic             boundary;
  logic [CNT_W-1:0] carrier_cnt;
  logic [CNT_W-1:0] carrier_hi;
  logic             pin_next;
  logic             pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= '{sel: tx_src_e'(tx_sel), inv: tx_inv, mod: mod_en};
  end

  opt_src_mux u_mux (
    .cfg       (cfg_q),
    .uart_txd  (uart_txd),
    .gpio_out2 (gpio_out2),
    .wpulse    (wpulse),
    .vpulse    (vpulse),
    .sel_bit   (sel_bit)
  );

  opt_carrier_gen #(.PERIOD(PERIOD)) u_car (
    .clk      (clk),
    .rst_n    (rst_n),
    .duty_sel (duty_sel),
    .cnt_q    (carrier_cnt),
    .hi_q     (carrier_hi),
    .boundary (boundary),
    .carrier  (carrier)
  );

  assign pin_next = cfg_q.mod ? (sel_bit & carrier) : sel_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_next;
  end

  assign tx_pin = pin_q;

  opt_rx_route u_rx (
    .rx_pin   (rx_pin),
    .rx_dis   (rx_dis),
    .uart_rxd (uart_rxd),
    .gpio_in1 (gpio_in1)
  );
endmodule

// File: rtl/opt_tx_modulator_chk.sv
module opt_tx_modulator_chk #(
  parameter int unsigned PERIOD = 128,
  parameter int unsigned CNT_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_q,
  input logic             sel_bit,
  input logic             boundary,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] hi,
  input logic             tx_pin,
  input logic             rx_dis,
  input logic             rx_pin,
  input logic             uart_rxd,
  input logic             gpio_in1
);
  // R3
  direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_q |=> tx_pin == $past(sel_bit));

  // R6
  gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q && !sel_bit) |=> !tx_pin);

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(hi));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> cnt == '0);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < PERIOD);

  // R8
  rx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dis ? (uart_rxd && gpio_in1 == rx_pin) : (!gpio_in1 && uart_rxd == rx_pin));

  // R9
  reset_pin_chk: assert property (@(posedge clk)
    !rst_n |-> (!tx_pin && cnt == '0));
endmodule

bind opt_tx_modulator opt_tx_modulator_chk #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mod_q    (cfg_q.mod),
  .sel_bit  (sel_bit),
  .boundary (boundary),
  .cnt      (carrier_cnt),
  .hi       (carrier_hi),
  .tx_pin   (tx_pin),
  .rx_dis   (rx_dis),
  .rx_pin   (rx_pin),
  .uart_rxd (uart_rxd),
  .gpio_in1 (gpio_in1)
);

// File: tb/opt_tx_modulator_bench.sv
`timescale 1ns/1ps
module opt_tx_modulator_bench;
  localparam int unsigned CLK_HZ = 1600;
  localparam int unsigned CAR_HZ = 100;
  localparam int P = CLK_HZ / CAR_HZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tx_sel = 2'd0, duty_sel = 2'd0;
  logic tx_inv = 1'b0, mod_en = 1'b0, rx_dis = 1'b0;
  logic uart_txd = 1'b0, gpio_out2 = 1'b0, wpulse = 1'b0, vpulse = 1'b0, rx_pin = 1'b0;
  logic tx_pin, uart_rxd, gpio_in1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  opt_tx_modulator #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ)) u_opt_tx_modulator (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .tx_inv(tx_inv), .mod_en(mod_en),
    .duty_sel(duty_sel), .rx_dis(rx_dis), .uart_txd(uart_txd), .gpio_out2(gpio_out2),
    .wpulse(wpulse), .vpulse(vpulse), .rx_pin(rx_pin), .tx_pin(tx_pin),
    .uart_rxd(uart_rxd), .gpio_in1(gpio_in1)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int hi_cycles(input int d);
    case (d)
      0: return P / 2;
      1: return (3 * P) / 8;
      2: return P / 4;
      default: return P / 8;
    endcase
  endfunction

  task automatic set_src(input int s, input bit v);
    uart_txd = 0; gpio_out2 = 0; wpulse = 0; vpulse = 0;
    case (s)
      0: uart_txd = v;
      1: gpio_out2 = v;
      2: wpulse = v;
      default: vpulse = v;
    endcase
  endtask

  // wait until the pin rises (sampled at negedges); bounded
  task automatic wait_rise();
    logic prev;
    prev = tx_pin;
    for (int i = 0; i < 4 * P; i++) begin
      @(negedge clk);
      if (tx_pin && !prev) return;
      prev = tx_pin;
    end
  endtask

  task automatic t_reset();
    cyc(3);
    check("R9 pin low in reset", tx_pin, 0);
    rst_n = 1'b1;
    cyc(3);
    check("R9 pin low after reset", tx_pin, 0);
  endtask

  task automatic t_select();
    for (int s = 0; s < 4; s++) begin
      tx_sel = 2'(s);
      set_src(s, 1'b1);
      cyc(3);
      check($sformatf("R1 sel %0d high", s), tx_pin, 1);
      // other sources high, chosen low
      uart_txd = 1; gpio_out2 = 1; wpulse = 1; vpulse = 1;
      set_src(s, 1'b0);
      uart_txd = (s != 0); gpio_out2 = (s != 1); wpulse = (s != 2); vpulse = (s != 3);
      cyc(2);
      check($sformatf("R1 sel %0d others ignored", s), tx_pin, 0);
    end
  endtask

  task automatic t_latency();
    tx_sel = 2'd1; set_src(1, 1'b0); cyc(3);
    gpio_out2 = 1'b1;
    @(negedge clk);
    check("R3 source one-cycle latency", tx_pin, 1);
    tx_sel = 2'd0; uart_txd = 1'b0;
    @(negedge clk);
    check("R3 control not yet at pin", tx_pin, 1);
    @(negedge clk);
    check("R3 control two-cycle latency", tx_pin, 0);
  endtask

  task automatic t_invert();
    tx_sel = 2'd2; set_src(2, 1'b1); tx_inv = 1'b1; cyc(3);
    check("R2 inverted high source", tx_pin, 0);
    wpulse = 1'b0; cyc(2);
    check("R2 inverted low source", tx_pin, 1);
    tx_inv = 1'b0; cyc(3);
  endtask

  task automatic t_gate_low();
    tx_sel = 2'd0; set_src(0, 1'b0); mod_en = 1'b1; cyc(3);
    begin
      int highs = 0;
      for (int i = 0; i < 2 * P; i++) begin
        @(negedge clk);
        highs += tx_pin;
      end
      check("R6 no carrier when bit low", highs, 0);
    end
    // inverted low bit becomes 1 and emits bursts
    tx_inv = 1'b1; cyc(P + 3);
    begin
      int highs = 0;
      for (int i = 0; i < P; i++) begin
        @(negedge clk);
        highs += tx_pin;
      end
      check("R2 inversion before gating", highs, hi_cycles(int'(duty_sel)));
    end
    tx_inv = 1'b0; cyc(3);
  endtask

  task automatic t_duty();
    tx_sel = 2'd3; set_src(3, 1'b1); mod_en = 1'b1;
    for (int d = 0; d < 4; d++) begin
      int highs = 0;
      duty_sel = 2'(d);
      cyc(2 * P + 3);
      for (int i = 0; i < P; i++) begin
        @(negedge clk);
        highs += tx_pin;
      end
      check($sformatf("R5 duty %0d high cycles", d), highs, hi_cycles(d));
    end
  endtask

  task automatic t_period();
    int n;
    duty_sel = 2'd1; cyc(2 * P);
    wait_rise();
    n = 0;
    begin
      logic prev;
      prev = tx_pin;
      for (int i = 0; i < 4 * P; i++) begin
        @(negedge clk);
        n++;
        if (tx_pin && !prev) break;
        prev = tx_pin;
      end
    end
    check("R4 carrier period", n, P);
  endtask

  task automatic t_duty_boundary();
    int run;
    duty_sel = 2'd0; cyc(2 * P);
    wait_rise();
    run = 1;
    cyc(2); run += 2;
    duty_sel = 2'd3;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (!tx_pin) break;
      run++;
    end
    check("R7 period in progress keeps old high time", run, hi_cycles(0));
    wait_rise();
    run = 1;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (!tx_pin) break;
      run++;
    end
    check("R7 next period uses new high time", run, hi_cycles(3));
    mod_en = 1'b0; duty_sel = 2'd0; cyc(3);
  endtask

  task automatic t_rx();
    rx_dis = 1'b0; rx_pin = 1'b0; #1;
    check("R8 uart follows pin low", uart_rxd, 0);
    check("R8 gpio idle when routed to uart", gpio_in1, 0);
    rx_pin = 1'b1; #1;
    check("R8 uart follows pin high", uart_rxd, 1);
    rx_dis = 1'b1; rx_pin = 1'b0; #1;
    check("R8 uart held idle", uart_rxd, 1);
    check("R8 gpio follows pin low", gpio_in1, 0);
    rx_pin = 1'b1; #1;
    check("R8 gpio follows pin high", gpio_in1, 1);
    rx_dis = 1'b0;
    cyc(1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_select();
    t_latency();
    t_invert();
    t_gate_low();
    t_duty();
    t_period();
    t_duty_boundary();
    t_rx();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule